// File: doc/BRIEF.md
# UART FIFO Service Request Generator

This block decides when a UART with 16-entry transmit and receive FIFOs needs attention from the host or a DMA engine. It takes the FIFO enable, a transfer-mode bit, the two programmed trigger-level codes and the occupancy counts of both FIFOs. From these it produces a receive request, a transmit request, a combined interrupt gated by per-direction enables, and the two transmitter line-status flags: space available and fully empty.

Single-transfer mode asks for service one character at a time. Receive requests service while any character is waiting. Transmit requests service while one slot is free. Block mode asks for service only at trigger thresholds. Receive requests when the receive FIFO has filled up to its trigger level. Transmit requests when the transmit FIFO has drained below its trigger level. This lets a DMA engine move a whole block per request. When the FIFOs are disabled, each direction behaves as a single holding register and the mode bit has no effect. All outputs are registered, so they follow the inputs by one clock.

Top module: `uart_fifo_svc_req`

## Requirements
- R1: While rst_ni is low, and after it is released until the first rising clock edge, every output is 0.
- R2: Trigger code 2'b00, 2'b01, 2'b10 and 2'b11 selects a level of 1, 4, 8 and 14 characters, for both the receive and transmit codes.
- R3: With fifo_en_i=1 and blk_mode_i=0, rx_req_o is 1 exactly when rx_count_i is not 0, and tx_req_o is 1 exactly when tx_count_i is below 16.
- R4: With fifo_en_i=1 and blk_mode_i=1, rx_req_o is 1 exactly when rx_count_i is greater than or equal to the receive trigger level.
- R5: With fifo_en_i=1 and blk_mode_i=1, tx_req_o is 1 exactly when tx_count_i is strictly less than the transmit trigger level.
- R6: With fifo_en_i=0, blk_mode_i and the trigger codes have no effect. rx_req_o is 1 when rx_count_i is not 0. tx_req_o is 1 when tx_count_i is 0.
- R7: irq_o is (rx_req_o AND rx_ie_i) OR (tx_req_o AND tx_ie_i), taking the enables from the same cycle as the counts. Clearing both enables drops irq_o on the next edge.
- R8: thr_space_o is 1 when tx_count_i is below 16 with the FIFOs enabled, and when tx_count_i is 0 with them disabled.
- R9: tx_empty_o is 1 exactly when tx_count_i is 0 and tx_shift_busy_i is 0.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, so it changes one cycle after an input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | FIFOs enabled |
| blk_mode_i | input | 1 | 0 single transfer, 1 block transfer |
| rx_trig_sel_i | input | 2 | Receive trigger-level code |
| tx_trig_sel_i | input | 2 | Transmit trigger-level code |
| rx_count_i | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count_i | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| tx_shift_busy_i | input | 1 | Transmit shifter is sending a character |
| rx_ie_i | input | 1 | Receive request enable for irq_o |
| tx_ie_i | input | 1 | Transmit request enable for irq_o |
| irq_o | output | 1 | Combined interrupt request |
| rx_req_o | output | 1 | Receive service request |
| tx_req_o | output | 1 | Transmit service request |
| thr_space_o | output | 1 | Transmitter has a free location |
| tx_empty_o | output | 1 | Transmit FIFO and shifter both empty |

## Verification
Some properties are checked on every cycle. Empty-implies-space, the disabled-enable interrupt drop and the full or empty boundaries in each mode all hold for any input. So do the single-register behaviour with the FIFOs disabled and the top-level block-mode thresholds. The exact trigger-level boundaries need the bench's scenarios to show them: each code sits at level minus one and at level. The same holds for the one-cycle latency, and for the full truth of every output under mixed random modes, codes and counts.

// File: rtl/uart_svc_pkg.sv
package uart_svc_pkg;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_code_e;

  typedef enum int unsigned {
    DIR_RX = 0,
    DIR_TX = 1
  } dir_e;
endpackage

// File: rtl/svc_trig_decode.sv
module svc_trig_decode #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] level_o
);
  import uart_svc_pkg::*;

  localparam logic [CNT_W-1:0] LVL_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LVL_QTR  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] LVL_HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] LVL_HIGH = CNT_W'(DEPTH - 2);

  always_comb begin
    unique case (trig_code_e'(sel_i))
      TRIG_ONE:  level_o = LVL_ONE;
      TRIG_QTR:  level_o = LVL_QTR;
      TRIG_HALF: level_o = LVL_HALF;
      default:   level_o = LVL_HIGH;
    endcase
  end
endmodule

// File: rtl/svc_dir_req.sv
module svc_dir_req #(
  parameter bit          IS_RX = 1'b1,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en_i,
  input  logic             blk_mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic is_zero;
  assign is_zero = (count_i == '0);

  generate
    if (IS_RX) begin : g_rx
      always_comb begin
        if (fifo_en_i && blk_mode_i) req_o = (count_i >= level_i);
        else                         req_o = !is_zero;
      end
    end else begin : g_tx
      always_comb begin
        if (!fifo_en_i)      req_o = is_zero;
        else if (blk_mode_i) req_o = (count_i < level_i);
        else                 req_o = (count_i < FULL);
      end
    end
  endgenerate
endmodule

// File: rtl/uart_fifo_svc_req.sv
module uart_fifo_svc_req #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             blk_mode_i,
  input  logic [1:0]       rx_trig_sel_i,
  input  logic [1:0]       tx_trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             tx_shift_busy_i,
  input  logic             rx_ie_i,
  input  logic             tx_ie_i,
  output logic             irq_o,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             thr_space_o,
  output logic             tx_empty_o
);
  import uart_svc_pkg::*;

  localparam int unsigned NDIR = 2;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [1:0]       sel   [NDIR];
  logic [CNT_W-1:0] cnt   [NDIR];
  logic [CNT_W-1:0] level [NDIR];
  logic [NDIR-1:0]  req;

  assign sel[DIR_RX] = rx_trig_sel_i;
  assign sel[DIR_TX] = tx_trig_sel_i;
  assign cnt[DIR_RX] = rx_count_i;
  assign cnt[DIR_TX] = tx_count_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    svc_trig_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dec (
      .sel_i   (sel[d]),
      .level_o (level[d])
    );
    svc_dir_req #(.IS_RX(d == DIR_RX), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_req (
      .fifo_en_i  (fifo_en_i),
      .blk_mode_i (blk_mode_i),
      .count_i    (cnt[d]),
      .level_i    (level[d]),
      .req_o      (req[d])
    );
  end

  logic space_d, empty_d, irq_d;
  assign space_d = fifo_en_i ? (tx_count_i < FULL) : (tx_count_i == '0);
  assign empty_d = (tx_count_i == '0) && !tx_shift_busy_i;
  assign irq_d   = (req[DIR_RX] && rx_ie_i) || (req[DIR_TX] && tx_ie_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      rx_req_o    <= 1'b0;
      tx_req_o    <= 1'b0;
      thr_space_o <= 1'b0;
      tx_empty_o  <= 1'b0;
    end else begin
      irq_o       <= irq_d;
      rx_req_o    <= req[DIR_RX];
      tx_req_o    <= req[DIR_TX];
      thr_space_o <= space_d;
      tx_empty_o  <= empty_d;
    end
  end
endmodule

// File: rtl/uart_fifo_svc_req_chk.sv
module uart_fifo_svc_req_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             blk_mode_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic             rx_ie_i,
  input logic             tx_ie_i,
  input logic             irq_o,
  input logic             rx_req_o,
  input logic             tx_req_o,
  input logic             thr_space_o,
  input logic             tx_empty_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HIGH = CNT_W'(DEPTH - 2);

  logic live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;
  end

  assert_empty_has_space_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && tx_empty_o |-> thr_space_o);

  assert_irq_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && !rx_ie_i && !tx_ie_i |=> !irq_o);

  assert_irq_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && irq_o |-> (rx_req_o || tx_req_o));

  assert_blk_rx_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && fifo_en_i && blk_mode_i && rx_count_i >= HIGH |=> rx_req_o);

  assert_blk_tx_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && fifo_en_i && blk_mode_i && tx_count_i == '0 |=> tx_req_o);

  assert_single_rx_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && fifo_en_i && !blk_mode_i && rx_count_i == '0 |=> !rx_req_o);

  assert_full_no_space_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && fifo_en_i && tx_count_i == FULL |=> (!thr_space_o && !tx_req_o));

  assert_nofifo_holding_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && !fifo_en_i && tx_count_i != '0 |=> (!tx_req_o && !thr_space_o));
endmodule

bind uart_fifo_svc_req uart_fifo_svc_req_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_en_i   (fifo_en_i),
  .blk_mode_i  (blk_mode_i),
  .rx_count_i  (rx_count_i),
  .tx_count_i  (tx_count_i),
  .rx_ie_i     (rx_ie_i),
  .tx_ie_i     (tx_ie_i),
  .irq_o       (irq_o),
  .rx_req_o    (rx_req_o),
  .tx_req_o    (tx_req_o),
  .thr_space_o (thr_space_o),
  .tx_empty_o  (tx_empty_o)
);

// File: tb/uart_fifo_svc_req_tb.sv
module uart_fifo_svc_req_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, blk = 1'b0, busy = 1'b0, rx_ie = 1'b0, tx_ie = 1'b0;
  logic [1:0] rx_sel = '0, tx_sel = '0;
  logic [CNT_W-1:0] rx_cnt = '0, tx_cnt = '0;
  logic irq, rx_req, tx_req, space, empty;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_svc_req #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .blk_mode_i(blk),
    .rx_trig_sel_i(rx_sel), .tx_trig_sel_i(tx_sel),
    .rx_count_i(rx_cnt), .tx_count_i(tx_cnt), .tx_shift_busy_i(busy),
    .rx_ie_i(rx_ie), .tx_ie_i(tx_ie),
    .irq_o(irq), .rx_req_o(rx_req), .tx_req_o(tx_req),
    .thr_space_o(space), .tx_empty_o(empty)
  );

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic exp_rx();
    if (fifo_en && blk) return int'(rx_cnt) >= lvl(rx_sel);
    return rx_cnt != 0;
  endfunction

  function automatic logic exp_tx();
    if (!fifo_en) return tx_cnt == 0;
    if (blk) return int'(tx_cnt) < lvl(tx_sel);
    return int'(tx_cnt) < DEPTH;
  endfunction

  function automatic string tag_dir();
    if (!fifo_en) return "R6";
    return "";
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (en=%b blk=%b rxc=%0d txc=%0d rxs=%0d txs=%0d)",
               req, act, exp, fifo_en, blk, rx_cnt, tx_cnt, rx_sel, tx_sel);
    end
  endtask

  task automatic check_all();
    logic er, et;
    er = exp_rx();
    et = exp_tx();
    chk(!fifo_en ? "R6" : (blk ? "R4" : "R3"), rx_req, er);
    chk(!fifo_en ? "R6" : (blk ? "R5" : "R3"), tx_req, et);
    chk("R7", irq, (er && rx_ie) || (et && tx_ie));
    chk("R8", space, fifo_en ? (int'(tx_cnt) < DEPTH) : (tx_cnt == 0));
    chk("R9", empty, (tx_cnt == 0) && !busy);
  endtask

  // drive at negedge, registered at posedge, checked at following negedge
  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_c0de);
    rst_n = 1'b0;
    rx_cnt = 5; tx_cnt = 0; fifo_en = 1; rx_ie = 1; tx_ie = 1;
    repeat (2) @(negedge clk);
    chk("R1", irq, 1'b0);
    chk("R1", rx_req, 1'b0);
    chk("R1", tx_req, 1'b0);
    chk("R1", space, 1'b0);
    chk("R1", empty, 1'b0);
    rst_n = 1'b1;
    #1;
    chk("R1", irq | rx_req | tx_req | space | empty, 1'b0);
    step();

    // R2: every code at level-1 and level, both directions, block mode
    fifo_en = 1; blk = 1; rx_ie = 1; tx_ie = 0; busy = 0;
    for (int c = 0; c < 4; c++) begin
      rx_sel = 2'(c); tx_sel = 2'(c);
      rx_cnt = CNT_W'(lvl(2'(c)) - 1); tx_cnt = CNT_W'(lvl(2'(c)) - 1);
      step();
      chk("R2", rx_req, 1'b0);
      chk("R2", tx_req, 1'b1);
      rx_cnt = CNT_W'(lvl(2'(c))); tx_cnt = CNT_W'(lvl(2'(c)));
      step();
      chk("R2", rx_req, 1'b1);
      chk("R2", tx_req, 1'b0);
    end

    // R7: clearing enables drops irq
    rx_ie = 1; tx_ie = 1; rx_cnt = 16; step();
    chk("R7", irq, 1'b1);
    rx_ie = 0; tx_ie = 0; step();
    chk("R7", irq, 1'b0);

    // R10: output holds until the next edge
    fifo_en = 1; blk = 0; rx_cnt = 0; step();
    chk("R10", rx_req, 1'b0);
    @(posedge clk); #1;
    rx_cnt = 1; #1;
    chk("R10", rx_req, 1'b0);
    @(posedge clk); #1;
    chk("R10", rx_req, 1'b1);
    step();

    // R6: mode bit and codes ignored when FIFOs are off
    fifo_en = 0; blk = 1; rx_sel = 3; tx_sel = 0; rx_cnt = 1; tx_cnt = 0; step();
    chk("R6", rx_req, 1'b1);
    chk("R6", tx_req, 1'b1);

    // R3/R8 full transmit FIFO in single mode
    fifo_en = 1; blk = 0; tx_cnt = 16; step();
    chk("R3", tx_req, 1'b0);
    chk("R8", space, 1'b0);
    // R9: busy shifter blocks empty
    tx_cnt = 0; busy = 1; step();
    chk("R9", empty, 1'b0);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      fifo_en = 1'($urandom_range(0, 3) != 0);
      blk     = 1'($urandom);
      rx_sel  = 2'($urandom);
      tx_sel  = 2'($urandom);
      rx_cnt  = CNT_W'($urandom_range(0, DEPTH));
      tx_cnt  = CNT_W'($urandom_range(0, DEPTH));
      busy    = 1'($urandom);
      rx_ie   = 1'($urandom);
      tx_ie   = 1'($urandom);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule